// File: doc/BRIEF.md
# High-Voltage Pin Fault Supervisor

This block watches over three high-voltage I/O pins: a bus pin, a status pin and a wake pin. Each pin reports a short-circuit condition as a synchronous flag. A short only counts as a fault after it has lasted a set number of clock cycles, and the wake pin needs a longer run than the other two. A qualified fault sets a sticky status bit. In active protection mode it also switches off that pin's driver. In passive protection mode the bus and status pins are only flagged. A die thermal flag switches off the status and wake drivers.

Software controls the block through one 8-bit configuration register. Writing a 1 to its self-clearing re-enable bit turns every driver back on and clears all pending status. The wake output comes from a software request level, and a one-shot timer drops it after a fixed hold time unless the timeout is disabled. An optional readback mode turns edges on the status and wake pin levels into a sticky event and shows those levels on a monitor output. The interrupt output is the OR of the sticky status bits, gated by an interrupt-enable input.

Top module: `hv_pin_supervisor`

## Requirements
- R1: After reset, `cfg_rdata` is 0x00, `drv_en` is 3'b111, `status` is 0, and `irq` and `wake_out` are 0.
- R2: A short on the bus pin (index 0) or the status pin (index 1) qualifies only on its (SHORT_CYC+1)th consecutive high sample. The matching `status` bit (bit 0 or bit 1) is set in the following cycle. A drop of the input restarts the count, so shorter runs have no effect.
- R3: A short on the wake pin (index 2) qualifies only on its (WAKE_SHORT_CYC+1)th consecutive high sample and sets `status` bit 2.
- R4: In active mode (configuration bit 0 = 0), a qualified short clears that pin's `drv_en` bit in the same cycle its status bit is set.
- R5: In passive mode (configuration bit 0 = 1), a qualified short on the bus or status pin sets its status bit and leaves its driver enabled. A qualified wake short always disables the wake driver.
- R6: A configuration write with bit 3 = 1 sets all of `drv_en` to 1 and clears all of `status`. Bit 3 always reads back as 0, and the other seven bits read back as written. A fault that qualifies in the same cycle as this write still takes effect.
- R7: While `therm_in` is high, each cycle sets `status` bit 4 and clears `drv_en` bits 1 and 2. `drv_en` bit 0 is not affected.
- R8: `irq` equals `irq_en` AND (any `status` bit set). Status bits stay set after the fault input drops, until a re-enable write clears them.
- R9: `wake_out` is `wake_req` gated by `drv_en` bit 2. When configuration bit 2 = 0, `wake_out` stays high for WAKE_HOLD_CYC cycles after `wake_req` rises, then goes low until `wake_req` falls. When configuration bit 2 = 1, there is no timeout.
- R10: With configuration bit 1 = 1, any change of `pin_level` (bit 0 = status pin, bit 1 = wake pin) between consecutive cycles sets `status` bit 3, and `mon_level` shows `pin_level`. With configuration bit 1 = 0, `mon_level` is 0 and no edge is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback (bit 3 always 0) |
| short_in | input | 3 | Per-pin short flags: bus, status, wake |
| therm_in | input | 1 | Thermal fault flag |
| pin_level | input | 2 | Live levels of status pin (bit 0) and wake pin (bit 1) |
| irq_en | input | 1 | Interrupt enable |
| wake_req | input | 1 | Software request level for the wake output |
| drv_en | output | 3 | Driver enables: bus, status, wake |
| status | output | 5 | Sticky: bus, status, wake short; pin edge; thermal |
| irq | output | 1 | High-voltage interrupt |
| wake_out | output | 1 | Wake pin drive |
| mon_level | output | 2 | Pin level monitor |

## Verification
Two cases are hard to reach from the ports. The first is a short that drops one sample before it would qualify and then returns, which must start its count again from zero. The stimulus gives runs of exactly SHORT_CYC and WAKE_SHORT_CYC samples, and back-to-back short runs split by a single low cycle. The second is a re-enable write made while a saturated short is still held high. After that write the status stays clear and the driver stays on, because the fault does not qualify a second time. A behavioural model, stepped on each rising edge, predicts every output. Directed checks then confirm each boundary.

// File: rtl/hvps_pkg.sv
// Shared indices for the high-voltage pin supervisor.
// Assumes a fixed set of three supervised pins.
package hvps_pkg;
    localparam int NPIN       = 3;
    localparam int PIN_BUS    = 0;
    localparam int PIN_STS    = 1;
    localparam int PIN_WAKE   = 2;

    localparam int ST_W       = 5;
    localparam int ST_EDGE    = 3;
    localparam int ST_THERM   = 4;

    localparam int CFG_W        = 8;
    localparam int CFG_PASSIVE  = 0;
    localparam int CFG_READBACK = 1;
    localparam int CFG_TMO_DIS  = 2;
    localparam int CFG_REEN     = 3;

    localparam int MON_W      = 2;
endpackage

// File: rtl/hvps_short_filter.sv
// Duration qualifier for one short-circuit flag. qualified pulses on the
// (THR_CYC+1)th consecutive high sample and not again until the input drops.
// Assumes fault_in is synchronous to clk.
module hvps_short_filter #(
    parameter int THR_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    output logic qualified
);
    localparam int CW = $clog2(THR_CYC + 2);
    localparam logic [CW-1:0] THR = CW'(THR_CYC);
    localparam logic [CW-1:0] SAT = CW'(THR_CYC + 1);

    logic [CW-1:0] run_q;

    // one-cycle event when the run reaches the threshold
    assign qualified = fault_in && (run_q == THR);

    // count consecutive high samples, restart on drop, saturate past threshold
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (!fault_in)
            run_q <= '0;
        else if (run_q != SAT)
            run_q <= run_q + 1'b1;
    end
endmodule

// File: rtl/hvps_wake_timer.sv
// One-shot hold timer for the wake output. The output follows the request
// for HOLD_CYC cycles after it rises, unless the timeout is disabled.
// Assumes req is a registered software level.
module hvps_wake_timer #(
    parameter int HOLD_CYC = 26_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic timeout_dis,
    input  logic drv_ok,
    output logic wake_out
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] HOLD = CW'(HOLD_CYC);

    logic [CW-1:0] held_q;

    // output is the request, gated by the driver and the expiry
    assign wake_out = req && drv_ok && (timeout_dis || (held_q != HOLD));

    // count cycles of an active request, clear when it is withdrawn
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (!req)
            held_q <= '0;
        else if (held_q != HOLD)
            held_q <= held_q + 1'b1;
    end
endmodule

// File: rtl/hvps_edge_watch.sv
// Change detector on sampled pin levels; flags any rising or falling edge
// between consecutive cycles while enabled. Assumes synchronous levels.
module hvps_edge_watch #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] level,
    output logic         edge_seen
);
    logic [W-1:0] prev_q;

    // any differing bit is an edge
    assign edge_seen = enable && (|(level ^ prev_q));

    // remember last sampled levels
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= level;
    end
endmodule

// File: rtl/hv_pin_supervisor.sv
// Fault supervisor for the bus, status and wake high-voltage pins.
// Qualifies shorts by duration, applies active or passive protection,
// holds sticky status, raises a shared interrupt, and times out the wake
// output. Assumes all fault and level inputs are synchronous to clk.
module hv_pin_supervisor
    import hvps_pkg::*;
#(
    parameter int SHORT_CYC      = 400,
    parameter int WAKE_SHORT_CYC = 8000,
    parameter int WAKE_HOLD_CYC  = 26_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic [NPIN-1:0]  short_in,
    input  logic             therm_in,
    input  logic [MON_W-1:0] pin_level,
    input  logic             irq_en,
    input  logic             wake_req,
    output logic [NPIN-1:0]  drv_en,
    output logic [ST_W-1:0]  status,
    output logic             irq,
    output logic             wake_out,
    output logic [MON_W-1:0] mon_level
);
    logic [CFG_W-1:0] cfg_q;
    logic [NPIN-1:0]  drv_q, drv_nxt;
    logic [ST_W-1:0]  sts_q, sts_nxt;
    logic [NPIN-1:0]  qual;
    logic             edge_hit;
    logic             reen;
    logic             passive;

    // per-pin duration qualifiers; the wake pin uses the longer threshold
    for (genvar p = 0; p < NPIN; p++) begin : g_filt
        localparam int THR = (p == PIN_WAKE) ? WAKE_SHORT_CYC : SHORT_CYC;
        hvps_short_filter #(.THR_CYC(THR)) i_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .fault_in  (short_in[p]),
            .qualified (qual[p])
        );
    end

    hvps_edge_watch #(.W(MON_W)) i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_q[CFG_READBACK]),
        .level     (pin_level),
        .edge_seen (edge_hit)
    );

    hvps_wake_timer #(.HOLD_CYC(WAKE_HOLD_CYC)) i_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (wake_req),
        .timeout_dis (cfg_q[CFG_TMO_DIS]),
        .drv_ok      (drv_q[PIN_WAKE]),
        .wake_out    (wake_out)
    );

    assign reen    = cfg_wr && cfg_wdata[CFG_REEN];
    assign passive = cfg_q[CFG_PASSIVE];

    // next driver enables: re-enable first, then faults override it
    always_comb begin
        drv_nxt = reen ? '1 : drv_q;
        for (int p = 0; p < NPIN; p++) begin
            if (qual[p] && ((p == PIN_WAKE) || !passive))
                drv_nxt[p] = 1'b0;
        end
        if (therm_in) begin
            drv_nxt[PIN_STS]  = 1'b0;
            drv_nxt[PIN_WAKE] = 1'b0;
        end
    end

    // next sticky status: clear on re-enable, new events always land
    always_comb begin
        sts_nxt = reen ? '0 : sts_q;
        sts_nxt[NPIN-1:0] = sts_nxt[NPIN-1:0] | qual;
        if (edge_hit) sts_nxt[ST_EDGE]  = 1'b1;
        if (therm_in) sts_nxt[ST_THERM] = 1'b1;
    end

    // state registers: configuration, driver enables, sticky status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            drv_q <= '1;
            sts_q <= '0;
        end else begin
            if (cfg_wr) begin
                cfg_q           <= cfg_wdata;
                cfg_q[CFG_REEN] <= 1'b0;
            end
            drv_q <= drv_nxt;
            sts_q <= sts_nxt;
        end
    end

    assign cfg_rdata = cfg_q;
    assign drv_en    = drv_q;
    assign status    = sts_q;
    assign irq       = irq_en && (|sts_q);
    assign mon_level = cfg_q[CFG_READBACK] ? pin_level : '0;
endmodule

// File: rtl/hv_pin_supervisor_chk.sv
// Property checker for hv_pin_supervisor, attached by bind below.
module hv_pin_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic [2:0] short_in,
    input logic       therm_in,
    input logic       wake_req,
    input logic [2:0] drv_en,
    input logic [4:0] status,
    input logic       wake_out
);
    // R8
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_wdata[3]) |=> (($past(status) & ~status) == 5'd0));

    // R4
    bus_off_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en[0]) |-> status[0]);

    // R5
    passive_keeps_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en[0]) |-> !$past(cfg_rdata[0]));

    // R6
    reenable_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[3] && (short_in == 3'b000) && !therm_in) |=> (drv_en == 3'b111));

    // R7
    thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        therm_in |=> (!drv_en[1] && !drv_en[2] && status[4]));

    // R9
    wake_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_req |-> !wake_out);
endmodule

bind hv_pin_supervisor hv_pin_supervisor_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .short_in  (short_in),
    .therm_in  (therm_in),
    .wake_req  (wake_req),
    .drv_en    (drv_en),
    .status    (status),
    .wake_out  (wake_out)
);

// File: tb/test_hv_pin_supervisor.sv
module test_hv_pin_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int SH   = 5;
    localparam int WK   = 12;
    localparam int HOLD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [2:0] short_in = 3'b000;
    logic       therm_in = 1'b0;
    logic [1:0] pin_level = 2'b00;
    logic       irq_en = 1'b0;
    logic       wake_req = 1'b0;
    logic [2:0] drv_en;
    logic [4:0] status;
    logic       irq;
    logic       wake_out;
    logic [1:0] mon_level;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hv_pin_supervisor #(
        .SHORT_CYC(SH), .WAKE_SHORT_CYC(WK), .WAKE_HOLD_CYC(HOLD)
    ) i_hv_pin_supervisor (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .short_in(short_in), .therm_in(therm_in),
        .pin_level(pin_level), .irq_en(irq_en), .wake_req(wake_req),
        .drv_en(drv_en), .status(status), .irq(irq), .wake_out(wake_out),
        .mon_level(mon_level)
    );

    // behavioural reference state
    int         m_run [3];
    logic [4:0] m_sts;
    logic [2:0] m_drv;
    logic [7:0] m_cfg;
    int         m_wc;
    logic [1:0] m_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 3; p++) m_run[p] = 0;
            m_sts = 5'd0; m_drv = 3'b111; m_cfg = 8'h00; m_wc = 0; m_prev = 2'b00;
        end else begin
            bit ev [3];
            bit reen;
            reen = cfg_wr && cfg_wdata[3];
            for (int p = 0; p < 3; p++) begin
                int lim;
                lim = (p == 2) ? WK : SH;
                ev[p] = 1'b0;
                if (short_in[p]) begin
                    if (m_run[p] == lim) ev[p] = 1'b1;
                    if (m_run[p] <= lim) m_run[p]++;
                end else m_run[p] = 0;
            end
            if (reen) begin m_sts = 5'd0; m_drv = 3'b111; end
            for (int p = 0; p < 3; p++) if (ev[p]) begin
                m_sts[p] = 1'b1;
                if (p == 2 || !m_cfg[0]) m_drv[p] = 1'b0;
            end
            if (m_cfg[1] && (pin_level != m_prev)) m_sts[3] = 1'b1;
            m_prev = pin_level;
            if (therm_in) begin m_sts[4] = 1'b1; m_drv[1] = 1'b0; m_drv[2] = 1'b0; end
            if (cfg_wr) m_cfg = cfg_wdata & 8'hF7;
            if (!wake_req) m_wc = 0; else if (m_wc < HOLD) m_wc++;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every output against the model, then return for new stimulus
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) begin
                chk("R6 cfg_rdata", cfg_rdata, m_cfg);
                chk("R4 drv_en", 8'(drv_en), 8'(m_drv));
                chk("R2 status", 8'(status), 8'(m_sts));
                chk("R8 irq", 8'(irq), 8'(irq_en && (m_sts != 0)));
                chk("R9 wake_out", 8'(wake_out),
                    8'(wake_req && m_drv[2] && (m_cfg[2] || m_wc < HOLD)));
                chk("R10 mon_level", 8'(mon_level), 8'(m_cfg[1] ? pin_level : 2'b00));
            end
        end
    endtask

    task automatic wr_cfg(input logic [7:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 cfg", cfg_rdata, 8'h00);
        chk("R1 drv", 8'(drv_en), 8'h07);
        chk("R1 status", 8'(status), 8'h00);
        chk("R1 irq_wake", 8'({irq, wake_out}), 8'h00);

        // R2 runs at exactly the threshold do not qualify
        short_in = 3'b001; tick(SH); short_in = 3'b000; tick();
        short_in = 3'b010; tick(SH); short_in = 3'b000; tick();
        short_in = 3'b011; tick(SH - 1); short_in = 3'b000; tick();
        short_in = 3'b011; tick(SH - 1); short_in = 3'b000; tick(2);
        chk("R2 short runs ignored", 8'(status), 8'h00);

        // R2 R4 active mode bus short qualifies and disables
        irq_en = 1'b1;
        short_in = 3'b001; tick(SH + 1);
        chk("R2 bus flagged", 8'(status), 8'h01);
        chk("R4 bus off", 8'(drv_en), 8'h06);
        short_in = 3'b000; tick(3);
        chk("R8 irq stays after drop", 8'(irq), 8'h01);
        irq_en = 1'b0; tick();
        chk("R8 irq gated", 8'(irq), 8'h00);

        // R6 re-enable restores and clears
        wr_cfg(8'h08);
        chk("R6 drv restored", 8'(drv_en), 8'h07);
        chk("R6 status cleared", 8'(status), 8'h00);
        chk("R6 bit reads zero", cfg_rdata, 8'h00);

        // R5 passive mode
        wr_cfg(8'hA1);
        chk("R6 readback", cfg_rdata, 8'hA1);
        short_in = 3'b011; tick(SH + 3); short_in = 3'b000; tick();
        chk("R5 flagged", 8'(status), 8'h03);
        chk("R5 drivers kept", 8'(drv_en), 8'h07);
        // R3 wake threshold
        short_in = 3'b100; tick(WK); short_in = 3'b000; tick();
        chk("R3 wake run ignored", 8'(status[2]), 8'h00);
        short_in = 3'b100; tick(WK + 1);
        chk("R3 wake flagged", 8'(status[2]), 8'h01);
        chk("R5 wake always off", 8'(drv_en[2]), 8'h00);
        // R6 re-enable while saturated short held
        wr_cfg(8'h08);
        tick(3);
        chk("R6 held short no repeat", 8'(status), 8'h00);
        chk("R6 held short drv", 8'(drv_en), 8'h07);
        short_in = 3'b000; tick();

        // R7 thermal
        therm_in = 1'b1; tick(); therm_in = 1'b0; tick(2);
        chk("R7 thermal flag", 8'(status), 8'h10);
        chk("R7 thermal drivers", 8'(drv_en), 8'h01);
        wake_req = 1'b1; tick(2);
        chk("R9 wake gated by driver", 8'(wake_out), 8'h00);
        wake_req = 1'b0;
        wr_cfg(8'h08);

        // R9 wake hold timeout
        wake_req = 1'b1; tick(2);
        chk("R9 wake high", 8'(wake_out), 8'h01);
        tick(HOLD + 2);
        chk("R9 wake expired", 8'(wake_out), 8'h00);
        wr_cfg(8'h04);
        chk("R9 timeout disabled", 8'(wake_out), 8'h01);
        tick(HOLD + 2);
        chk("R9 no expiry", 8'(wake_out), 8'h01);
        wake_req = 1'b0; tick();

        // R10 readback edges
        pin_level = 2'b01; tick(2);
        chk("R10 no edge when off", 8'(status), 8'h00);
        chk("R10 monitor off", 8'(mon_level), 8'h00);
        wr_cfg(8'h02);
        chk("R10 monitor on", 8'(mon_level), 8'h01);
        tick(2);
        chk("R10 steady no edge", 8'(status), 8'h00);
        pin_level = 2'b11; tick();
        chk("R10 edge flagged", 8'(status), 8'h08);
        wr_cfg(8'h0A);
        pin_level = 2'b10; tick();
        chk("R10 falling edge", 8'(status), 8'h08);

        // R6 same-cycle fault beats re-enable
        wr_cfg(8'h08);
        short_in = 3'b001; tick(SH);
        cfg_wr = 1'b1; cfg_wdata = 8'h08; tick(); cfg_wr = 1'b0;
        chk("R6 event wins", 8'(drv_en[0]), 8'h00);
        short_in = 3'b000; tick(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule